// File: doc/BRIEF.md
# Two-Wire Register Access Slave

This block is the serial front end of a small ten-entry register file. It listens on a two-wire bus (clock line and open-drain data line, both already sampled into the core clock domain). It recognises START and STOP conditions and compares the first byte after a START against its own 7-bit device address. When the address matches, the block either takes a register pointer followed by data bytes to write, or returns register contents starting at the current pointer. After every data byte the pointer advances. Past the last register it wraps back to the first, so a master can stream across the whole map in one transaction.

The register file sits outside the block. It receives a registered one-cycle write strobe with address and data, and supplies read data combinationally for the address the block presents. A power-fail input locks the timekeeping registers (addresses 00h to 06h). While it is asserted, the device address is refused. If the supply drops in the middle of a transaction, writes to the locked range are discarded and reads from it return all ones. Registers 07h to 09h stay reachable.

Top module: `tw_regif_slave`

## Requirements
- R1: After a START, the first eight bits (MSB first) hold the 7-bit device address `DEV_ADDR` (default 68h) in bits 7..1 and the direction in bit 0 (0 = write, 1 = read). When the address matches and power-fail is low, the block pulls SDA low for the ninth clock.
- R2: On an address mismatch the block does not acknowledge and leaves SDA released. It acknowledges nothing and writes nothing until the next START.
- R3: In a write transaction, the first byte after the address loads the register pointer and is acknowledged. A value above 09h loads 00h.
- R4: Each further written byte produces exactly one single-cycle write strobe at the current pointer with that byte as data. The byte is acknowledged, and the pointer then advances by one.
- R5: The pointer wraps from 09h to 00h, for both reads and writes.
- R6: In a read transaction, the block sends the register at the pointer MSB first, advances the pointer after each byte, and sends the next byte when the master acknowledges.
- R7: After a master NACK, the block releases SDA and sends no further bits. The pointer stays one past the last byte sent.
- R8: A STOP ends the transaction. Clocks and bytes that follow it without a new START get no acknowledge and cause no write.
- R9: A repeated START restarts address matching without changing the pointer.
- R10: While power-fail is high, the device address is not acknowledged.
- R11: If power-fail rises during a transaction, writes to 00h–06h are dropped but still acknowledged, and the pointer still advances. Writes to 07h–09h still take effect. Reads from 00h–06h return FFh.
- R12: After reset the pointer is 00h, SDA is released and no write strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Sampled bus clock line |
| sda_i | input | 1 | Sampled bus data line |
| pwr_fail_i | input | 1 | Main supply below threshold; locks 00h–06h |
| rd_data_i | input | 8 | Register file contents at `rd_addr_o` |
| rd_addr_o | output | AW (4) | Current register pointer, used as read address |
| wr_en_o | output | 1 | One-cycle register write strobe |
| wr_addr_o | output | AW (4) | Write address, valid with `wr_en_o` |
| wr_data_o | output | 8 | Write data, valid with `wr_en_o` |
| sda_drive_low_o | output | 1 | Pull the data line low when high |

## Verification
The bench walks every start pointer through multi-byte writes and eleven-byte reads. A pointer that fails to wrap at 09h, or wraps one register early, shows up as wrong data or a wrong final pointer. It tries all 128 device addresses and all sixteen low pointer values. A loose address compare would acknowledge a neighbour. Clamping out-of-range pointer values the wrong way would strobe the wrong register. Power-fail is raised both before the address byte and in mid-transaction. A lockout tied only to the address phase would let 05h and 06h be overwritten or read back. A lockout that also stopped the pointer would misplace the 07h write. Bytes clocked after a STOP or a NACK must draw no acknowledge and no strobe. A state machine that forgets to return to idle would respond to them.

// File: rtl/tw_regif_pkg.sv
package tw_regif_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CNT_W  = $clog2(BYTE_W + 1);

  typedef logic [CNT_W-1:0] bitcnt_t;

  localparam bitcnt_t CNT_FULL = bitcnt_t'(BYTE_W);
  localparam bitcnt_t CNT_LAST = bitcnt_t'(BYTE_W - 1);

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_PTR,
    ST_PTR_ACK,
    ST_WDATA,
    ST_WACK,
    ST_RDATA,
    ST_RACK
  } tw_state_e;

endpackage

// File: rtl/tw_bus_events.sv
module tw_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o,
  output logic sda_o
);

  logic scl_d, sda_d, scl_q, sda_q;

  // idle bus level is high on both lines
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_d <= scl_i;
      sda_d <= sda_i;
      scl_q <= scl_d;
      sda_q <= sda_d;
    end
  end

  assign scl_rise_o = scl_d & ~scl_q;
  assign scl_fall_o = ~scl_d & scl_q;
  // data edges while the clock stays high mark bus conditions
  assign start_o    = scl_d & scl_q & sda_q & ~sda_d;
  assign stop_o     = scl_d & scl_q & ~sda_q & sda_d;
  assign sda_o      = sda_d;

  // R1
  events_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({scl_rise_o, scl_fall_o, start_o, stop_o}));

endmodule

// File: rtl/tw_byte_shift.sv
module tw_byte_shift
  import tw_regif_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_en,
  input  logic              load_en,
  input  logic [BYTE_W-1:0] load_val,
  input  logic              rx_en,
  input  logic              rx_bit,
  input  logic              tx_en,
  output logic [BYTE_W-1:0] data_o,
  output bitcnt_t           cnt_o
);

  logic [BYTE_W-1:0] data_q, data_d;
  bitcnt_t           cnt_q, cnt_d;
  logic              upd;

  assign upd = clear_en | load_en | rx_en | tx_en;

  always_comb begin
    data_d = data_q;
    cnt_d  = cnt_q;
    if (clear_en) begin
      cnt_d = '0;
    end else if (load_en) begin
      data_d = load_val;
      cnt_d  = '0;
    end else if (rx_en) begin
      data_d = {data_q[BYTE_W-2:0], rx_bit};
      cnt_d  = cnt_q + bitcnt_t'(1);
    end else if (tx_en) begin
      data_d = {data_q[BYTE_W-2:0], 1'b1};
      cnt_d  = cnt_q + bitcnt_t'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      cnt_q  <= '0;
    end else if (upd) begin
      data_q <= data_d;
      cnt_q  <= cnt_d;
    end
  end

  assign data_o = data_q;
  assign cnt_o  = cnt_q;

  // R6
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_FULL);

endmodule

// File: rtl/tw_reg_ptr.sv
module tw_reg_ptr #(
  parameter  int unsigned NUM_REGS = 10,
  parameter  int unsigned BYTE_W   = 8,
  localparam int unsigned AW       = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [BYTE_W-1:0] load_val,
  input  logic              inc_en,
  output logic [AW-1:0]     ptr_o
);

  localparam logic [AW-1:0]     LAST  = AW'(NUM_REGS - 1);
  localparam logic [BYTE_W-1:0] LIMIT = BYTE_W'(NUM_REGS);

  logic [AW-1:0] ptr_q, ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (load_en) begin
      ptr_d = (load_val < LIMIT) ? load_val[AW-1:0] : '0;
    end else if (inc_en) begin
      ptr_d = (ptr_q == LAST) ? '0 : ptr_q + AW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (load_en | inc_en) begin
      ptr_q <= ptr_d;
    end
  end

  assign ptr_o = ptr_q;

  // R5
  ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q <= LAST);

  // R5
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_en && !load_en && ptr_q == LAST) |=> (ptr_q == '0));

endmodule

// File: rtl/tw_regif_slave.sv
module tw_regif_slave
  import tw_regif_pkg::*;
#(
  parameter  logic [6:0]  DEV_ADDR = 7'h68,
  parameter  int unsigned NUM_REGS = 10,
  parameter  int unsigned LOCK_TOP = 6,
  localparam int unsigned AW       = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              pwr_fail_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic [AW-1:0]     rd_addr_o,
  output logic              wr_en_o,
  output logic [AW-1:0]     wr_addr_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              sda_drive_low_o
);

  localparam logic [AW-1:0] LOCK_A = AW'(LOCK_TOP);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  // bus events
  logic ev_rise, ev_fall, ev_start, ev_stop, ev_sda;

  tw_bus_events u_events (
    .clk        (clk),
    .rst_n      (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_rise_o (ev_rise),
    .scl_fall_o (ev_fall),
    .start_o    (ev_start),
    .stop_o     (ev_stop),
    .sda_o      (ev_sda)
  );

  // byte shifter
  logic              sh_clear, sh_load, sh_rx, sh_tx;
  logic [BYTE_W-1:0] sh_data, tx_byte;
  bitcnt_t           sh_cnt;

  tw_byte_shift u_shift (
    .clk      (clk),
    .rst_n    (rst_ni),
    .clear_en (sh_clear),
    .load_en  (sh_load),
    .load_val (tx_byte),
    .rx_en    (sh_rx),
    .rx_bit   (ev_sda),
    .tx_en    (sh_tx),
    .data_o   (sh_data),
    .cnt_o    (sh_cnt)
  );

  // register pointer
  logic          ptr_load, ptr_inc;
  logic [AW-1:0] ptr;

  tw_reg_ptr #(
    .NUM_REGS (NUM_REGS),
    .BYTE_W   (BYTE_W)
  ) u_ptr (
    .clk      (clk),
    .rst_n    (rst_ni),
    .load_en  (ptr_load),
    .load_val (sh_data),
    .inc_en   (ptr_inc),
    .ptr_o    (ptr)
  );

  // control state
  tw_state_e         state_q, state_d;
  logic              rw_q, rw_d;
  logic              nack_q, nack_d;
  logic              wr_fire, wr_en_d, wr_en_q;
  logic [AW-1:0]     wr_addr_q;
  logic [BYTE_W-1:0] wr_data_q;
  logic              byte_done, ptr_locked, dev_match;

  assign byte_done  = (sh_cnt == CNT_FULL);
  assign ptr_locked = pwr_fail_i && (ptr <= LOCK_A);
  assign dev_match  = (sh_data[BYTE_W-1:1] == DEV_ADDR);
  assign tx_byte    = ptr_locked ? '1 : rd_data_i;
  assign wr_en_d    = wr_fire && !ptr_locked;

  always_comb begin
    state_d  = state_q;
    rw_d     = rw_q;
    nack_d   = nack_q;
    sh_clear = 1'b0;
    sh_load  = 1'b0;
    sh_rx    = 1'b0;
    sh_tx    = 1'b0;
    ptr_load = 1'b0;
    ptr_inc  = 1'b0;
    wr_fire  = 1'b0;
    if (ev_start) begin
      state_d  = ST_DEV;
      sh_clear = 1'b1;
    end else if (ev_stop) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          state_d = ST_IDLE;
        end
        ST_DEV: begin
          if (ev_rise && !byte_done) sh_rx = 1'b1;
          if (ev_fall && byte_done) begin
            if (dev_match && !pwr_fail_i) begin
              state_d = ST_DEV_ACK;
              rw_d    = sh_data[0];
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
        ST_DEV_ACK: begin
          if (ev_fall) begin
            if (rw_q) begin
              sh_load = 1'b1;
              state_d = ST_RDATA;
            end else begin
              sh_clear = 1'b1;
              state_d  = ST_PTR;
            end
          end
        end
        ST_PTR: begin
          if (ev_rise && !byte_done) sh_rx = 1'b1;
          if (ev_fall && byte_done) begin
            ptr_load = 1'b1;
            state_d  = ST_PTR_ACK;
          end
        end
        ST_PTR_ACK, ST_WACK: begin
          if (ev_fall) begin
            sh_clear = 1'b1;
            state_d  = ST_WDATA;
          end
        end
        ST_WDATA: begin
          if (ev_rise && !byte_done) sh_rx = 1'b1;
          if (ev_fall && byte_done) begin
            wr_fire = 1'b1;
            ptr_inc = 1'b1;
            state_d = ST_WACK;
          end
        end
        ST_RDATA: begin
          if (ev_fall) begin
            if (sh_cnt == CNT_LAST) begin
              ptr_inc = 1'b1;
              state_d = ST_RACK;
            end else begin
              sh_tx = 1'b1;
            end
          end
        end
        ST_RACK: begin
          if (ev_rise) nack_d = ev_sda;
          if (ev_fall) begin
            if (!nack_q) begin
              sh_load = 1'b1;
              state_d = ST_RDATA;
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
        default: begin
          state_d = ST_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      rw_q    <= 1'b0;
      nack_q  <= 1'b0;
      wr_en_q <= 1'b0;
    end else begin
      state_q <= state_d;
      rw_q    <= rw_d;
      nack_q  <= nack_d;
      wr_en_q <= wr_en_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_addr_q <= '0;
      wr_data_q <= '0;
    end else if (wr_fire) begin
      wr_addr_q <= ptr;
      wr_data_q <= sh_data;
    end
  end

  assign rd_addr_o       = ptr;
  assign wr_en_o         = wr_en_q;
  assign wr_addr_o       = wr_addr_q;
  assign wr_data_o       = wr_data_q;
  assign sda_drive_low_o = (state_q inside {ST_DEV_ACK, ST_PTR_ACK, ST_WACK}) ||
                           (state_q == ST_RDATA && !sh_data[BYTE_W-1]);

  // R11
  lock_wr_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_en_o && (wr_addr_o <= LOCK_A)) |-> !$past(pwr_fail_i));

  // R10
  dev_refuse_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_DEV && ev_fall && byte_done && pwr_fail_i) |=> !sda_drive_low_o);

  // R2
  mismatch_idle_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_DEV && ev_fall && byte_done && !dev_match) |=> (state_q == ST_IDLE));

  // R8
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    ev_stop |=> !sda_drive_low_o);

  // R4
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    wr_en_o |=> !wr_en_o);

endmodule

// File: tb/tw_regif_slave_tb_top.sv
`timescale 1ns/1ps
module tw_regif_slave_tb_top;

  localparam int Q     = 4;
  localparam int NREG  = 10;
  localparam int DADDR = 'h68;

  logic       clk;
  logic       rst_n;
  logic       scl;
  logic       mst_sda;
  logic       pwr_fail;
  logic [7:0] rd_data;
  logic [3:0] rd_addr;
  logic       wr_en;
  logic [3:0] wr_addr;
  logic [7:0] wr_data;
  logic       sda_low;
  logic       sda_line;

  assign sda_line = mst_sda & ~sda_low;

  tw_regif_slave dut_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .scl_i           (scl),
    .sda_i           (sda_line),
    .pwr_fail_i      (pwr_fail),
    .rd_data_i       (rd_data),
    .rd_addr_o       (rd_addr),
    .wr_en_o         (wr_en),
    .wr_addr_o       (wr_addr),
    .wr_data_o       (wr_data),
    .sda_drive_low_o (sda_low)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // register file model driven only by the write port
  logic [7:0] mem [NREG];
  int         wr_cnt;
  int         last_wr_addr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) mem[i] <= 8'h00;
      wr_cnt       <= 0;
      last_wr_addr <= -1;
    end else if (wr_en) begin
      mem[wr_addr] <= wr_data;
      wr_cnt       <= wr_cnt + 1;
      last_wr_addr <= int'(wr_addr);
    end
  end

  assign rd_data = (rd_addr < 4'(NREG)) ? mem[rd_addr] : 8'h00;

  int n_chk;
  int n_fail;
  bit done;
  int exp_mem [NREG];

  task automatic chk_eq(input string req, input int act, input int exp_v);
    n_chk++;
    if (act != exp_v) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
    end
  endtask

  task automatic qwait();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    mst_sda = 1'b1; qwait();
    scl = 1'b1;     qwait();
    mst_sda = 1'b0; qwait();
    scl = 1'b0;     qwait();
  endtask

  task automatic bus_stop();
    mst_sda = 1'b0; qwait();
    scl = 1'b1;     qwait();
    mst_sda = 1'b1; qwait();
  endtask

  task automatic put_bit(input logic b);
    mst_sda = b; qwait();
    scl = 1'b1;  qwait(); qwait();
    scl = 1'b0;  qwait();
  endtask

  task automatic get_bit(output logic b);
    mst_sda = 1'b1; qwait();
    scl = 1'b1;     qwait();
    b = sda_line;   qwait();
    scl = 1'b0;     qwait();
  endtask

  task automatic put_byte(input logic [7:0] v, output bit ack);
    logic a;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(a);
    ack = !a;
  endtask

  task automatic get_byte(output logic [7:0] v, input bit ack_it);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    put_bit(!ack_it);
  endtask

  // write transaction setting the pointer only, then STOP
  task automatic set_ptr(input int p);
    bit ack;
    bus_start();
    put_byte(8'((DADDR << 1) | 0), ack);
    chk_eq("R1 address ack", int'(ack), 1);
    put_byte(8'(p), ack);
    chk_eq("R3 pointer ack", int'(ack), 1);
    bus_stop();
  endtask

  initial begin
    bit         ack;
    logic       b;
    logic [7:0] v;
    int         base_cnt;
    int         p_exp;

    n_chk = 0; n_fail = 0; done = 1'b0;
    scl = 1'b1; mst_sda = 1'b1; pwr_fail = 1'b0;
    for (int i = 0; i < NREG; i++) exp_mem[i] = 0;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R12 reset state
    chk_eq("R12 sda released", int'(sda_low), 0);
    chk_eq("R12 no strobe", int'(wr_en), 0);
    chk_eq("R12 pointer", int'(rd_addr), 0);

    // R4 R5: write three bytes from every start pointer
    for (int p = 0; p < NREG; p++) begin
      base_cnt = wr_cnt;
      bus_start();
      put_byte(8'((DADDR << 1) | 0), ack);
      chk_eq("R1 address ack", int'(ack), 1);
      put_byte(8'(p), ack);
      chk_eq("R3 pointer ack", int'(ack), 1);
      for (int k = 0; k < 3; k++) begin
        v = 8'((p * 37 + k * 11 + 5) & 'hFF);
        put_byte(v, ack);
        chk_eq("R4 data ack", int'(ack), 1);
        exp_mem[(p + k) % NREG] = int'(v);
      end
      bus_stop();
      chk_eq("R4 strobe count", wr_cnt - base_cnt, 3);
      chk_eq("R5 pointer after write", int'(rd_addr), (p + 3) % NREG);
    end
    for (int i = 0; i < NREG; i++) chk_eq("R4 register content", int'(mem[i]), exp_mem[i]);

    // R6 R7 R9: read eleven bytes from every start pointer via repeated START
    for (int p = 0; p < NREG; p++) begin
      bus_start();
      put_byte(8'((DADDR << 1) | 0), ack);
      put_byte(8'(p), ack);
      bus_start();
      put_byte(8'((DADDR << 1) | 1), ack);
      chk_eq("R9 read address ack", int'(ack), 1);
      for (int k = 0; k < 11; k++) begin
        get_byte(v, k != 10);
        chk_eq((k == 0) ? "R9 first byte at kept pointer" : "R6 read byte",
               int'(v), exp_mem[(p + k) % NREG]);
      end
      get_bit(b);
      chk_eq("R7 released after NACK", int'(b), 1);
      bus_stop();
      chk_eq("R7 pointer after NACK", int'(rd_addr), (p + 11) % NREG);
    end

    // R1 R2: every device address
    for (int a = 0; a < 128; a++) begin
      base_cnt = wr_cnt;
      bus_start();
      put_byte(8'((a << 1) | 0), ack);
      if (a == DADDR) begin
        chk_eq("R1 matching address ack", int'(ack), 1);
      end else begin
        chk_eq("R2 foreign address nack", int'(ack), 0);
        put_byte(8'h02, ack);
        chk_eq("R2 no ack after mismatch", int'(ack), 0);
        put_byte(8'hEE, ack);
        chk_eq("R2 no write after mismatch", wr_cnt - base_cnt, 0);
      end
      bus_stop();
    end

    // R3: pointer byte values 0..15
    for (int pv = 0; pv < 16; pv++) begin
      p_exp = (pv < NREG) ? pv : 0;
      bus_start();
      put_byte(8'((DADDR << 1) | 0), ack);
      put_byte(8'(pv), ack);
      chk_eq("R3 pointer ack", int'(ack), 1);
      v = 8'(pv ^ 'hA5);
      put_byte(v, ack);
      bus_stop();
      exp_mem[p_exp] = int'(v);
      chk_eq("R3 write address from pointer byte", last_wr_addr, p_exp);
      chk_eq("R3 written data", int'(mem[p_exp]), int'(v));
    end

    // R8: bytes after STOP without START
    base_cnt = wr_cnt;
    put_byte(8'((DADDR << 1) | 0), ack);
    chk_eq("R8 no ack after STOP", int'(ack), 0);
    put_byte(8'h55, ack);
    chk_eq("R8 no ack on stray byte", int'(ack), 0);
    chk_eq("R8 no write after STOP", wr_cnt - base_cnt, 0);
    bus_stop();

    // R10: power fail refuses the device address
    pwr_fail = 1'b1;
    bus_start();
    put_byte(8'((DADDR << 1) | 0), ack);
    chk_eq("R10 write address refused", int'(ack), 0);
    bus_start();
    put_byte(8'((DADDR << 1) | 1), ack);
    chk_eq("R10 read address refused", int'(ack), 0);
    bus_stop();
    pwr_fail = 1'b0;

    // R11: power fail during a write from 05h
    base_cnt = wr_cnt;
    bus_start();
    put_byte(8'((DADDR << 1) | 0), ack);
    put_byte(8'h05, ack);
    pwr_fail = 1'b1;
    put_byte(8'h11, ack);
    chk_eq("R11 locked write still acked", int'(ack), 1);
    put_byte(8'h22, ack);
    put_byte(8'h33, ack);
    chk_eq("R11 open write acked", int'(ack), 1);
    bus_stop();
    pwr_fail = 1'b0;
    exp_mem[7] = 'h33;
    chk_eq("R11 one strobe only", wr_cnt - base_cnt, 1);
    chk_eq("R11 05h kept", int'(mem[5]), exp_mem[5]);
    chk_eq("R11 06h kept", int'(mem[6]), exp_mem[6]);
    chk_eq("R11 07h written", int'(mem[7]), exp_mem[7]);
    chk_eq("R11 pointer advanced", int'(rd_addr), 8);

    // R11: power fail during a read from 07h
    set_ptr(7);
    bus_start();
    put_byte(8'((DADDR << 1) | 1), ack);
    pwr_fail = 1'b1;
    for (int k = 0; k < 5; k++) begin
      get_byte(v, k != 4);
      chk_eq("R11 read under lockout", int'(v),
             ((7 + k) % NREG <= 6) ? 'hFF : exp_mem[(7 + k) % NREG]);
    end
    bus_stop();
    pwr_fail = 1'b0;
    chk_eq("R12 released at end", int'(sda_low), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

endmodule